// File: doc/BRIEF.md
# Masked-Write Serial Frame Register Pair

This block holds the 32-bit parallel frame that a serializing SPI-style peripheral shifts out. Software changes the frame through two word registers on a simple synchronous register bus. One register covers the upper sixteen frame bits and the other covers the lower sixteen. Each write word carries a per-bit enable mask and the new bit values together. Any subset of one half can therefore be set or cleared in a single bus cycle, with no read-modify-write and no race against other writers of the same half.

The frame is held in flops and driven straight to `frame_o`. A frame bit of 1 puts a logic high in that serial position and a 0 puts a logic low. A read returns the current half in the low halfword. The mask halfword reads as zero, because the mask is not stored.

Top module: `mask_frame_regs`

## Requirements
- R1: In a write word, bits 31..16 form the mask and bits 15..0 form the data. Mask bit k (word bit 16+k) pairs with data bit k (word bit k).
- R2: For each mask bit that is 1, the matching frame bit takes the paired data bit on the clock edge that accepts the write.
- R3: For each mask bit that is 0, the matching frame bit keeps its previous value.
- R4: A write to byte address 0x0D04 (the low register) updates only frame bits 15..0.
- R5: A write to byte address 0x0D00 (the high register) updates only frame bits 31..16.
- R6: While rst_ni is low, and after it is released, all frame bits are 0 until the first accepted write.
- R7: A read of either register returns 0 in bits 31..16 and the current frame half in bits 15..0. Read data is combinational from addr_i.
- R8: A write with mask 0x0000 leaves that half unchanged. A write with mask 0xFFFF replaces that half with the data field.
- R9: Writes to the high and low registers in consecutive cycles both take effect, and neither update is lost.
- R10: frame_o changes only on the rising clock edge that samples we_i high at a register address. It is stable in every cycle with no accepted write.
- R11: A write to any other address changes no frame bit, and a read of any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 16 | Byte address |
| we_i | input | 1 | Write enable, sampled on the rising edge |
| wdata_i | input | 32 | Write word: mask in 31..16, data in 15..0 |
| rdata_o | output | 32 | Read data for addr_i |
| frame_o | output | 32 | Parallel frame to the serializer |

## Verification
The assertions assume that `we_i` is a defined level on every rising edge after reset. They also assume that `addr_i` and `wdata_i` are stable around the edge whenever `we_i` is high. The bench drives all inputs on the falling edge and holds `we_i` low during reset, so every write is seen whole by exactly one edge. Random addresses are drawn mostly from the two register addresses, and a few stray addresses are mixed in to exercise the decode.

// File: rtl/mask_frame_pkg.sv
package mask_frame_pkg;
  localparam int unsigned FRAME_W = 32;
  localparam int unsigned HALF_W  = FRAME_W / 2;
  localparam int unsigned NUM_HALVES = 2;

  typedef logic [HALF_W-1:0] half_t;

  typedef struct packed {
    half_t mask;
    half_t data;
  } wr_word_t;

  function automatic half_t merge_half(half_t cur, half_t mask, half_t data);
    return (cur & ~mask) | (data & mask);
  endfunction
endpackage

// File: rtl/mask_addr_decode.sv
module mask_addr_decode #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned NUM_REGS = 2,
  parameter logic [NUM_REGS*ADDR_W-1:0] REG_ADDRS = '0
) (
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [NUM_REGS-1:0] sel_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_cmp
    assign sel_o[g] = (addr_i == REG_ADDRS[g*ADDR_W +: ADDR_W]);
  end
endmodule

// File: rtl/mask_half_reg.sv
module mask_half_reg
  import mask_frame_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_i,
  input  half_t mask_i,
  input  half_t data_i,
  output half_t q_o
);
  half_t q_q;
  logic  past_ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_q <= '0;
    else if (wr_i) q_q <= merge_half(q_q, mask_i, data_i);
  end

  // qualifies $past checks to cycles after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok_q <= 1'b0;
    else         past_ok_q <= 1'b1;
  end

  assign q_o = q_q;

  AST_MASKED_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q && $past(wr_i) |-> ((q_q & $past(mask_i)) == ($past(data_i) & $past(mask_i)))); // R2
  AST_UNMASKED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q && $past(wr_i) |-> ((q_q & ~$past(mask_i)) == ($past(q_q) & ~$past(mask_i)))); // R3
  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q && !$past(wr_i) |-> $stable(q_q)); // R10
endmodule

// File: rtl/mask_frame_regs.sv
module mask_frame_regs
  import mask_frame_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] LO_ADDR = 16'h0D04,
  parameter logic [ADDR_W-1:0] HI_ADDR = 16'h0D00
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               we_i,
  input  logic [FRAME_W-1:0] wdata_i,
  output logic [FRAME_W-1:0] rdata_o,
  output logic [FRAME_W-1:0] frame_o
);
  // index 0 = low half, index 1 = high half
  localparam logic [NUM_HALVES*ADDR_W-1:0] ADDRS = {HI_ADDR, LO_ADDR};

  logic [NUM_HALVES-1:0] sel;
  half_t                 half_q [NUM_HALVES];
  wr_word_t              wword;
  half_t                 rd_half;

  assign wword = wr_word_t'(wdata_i);

  mask_addr_decode #(
    .ADDR_W   (ADDR_W),
    .NUM_REGS (NUM_HALVES),
    .REG_ADDRS(ADDRS)
  ) u_dec (
    .addr_i(addr_i),
    .sel_o (sel)
  );

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    mask_half_reg u_reg (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .wr_i  (we_i && sel[h]),
      .mask_i(wword.mask),
      .data_i(wword.data),
      .q_o   (half_q[h])
    );
    assign frame_o[h*HALF_W +: HALF_W] = half_q[h];
  end

  always_comb begin
    rd_half = '0;
    for (int i = 0; i < NUM_HALVES; i++)
      if (sel[i]) rd_half = half_q[i];
  end

  assign rdata_o = {{HALF_W{1'b0}}, rd_half};

  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel)); // R11
  AST_READ_MASK_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[FRAME_W-1:HALF_W] == '0); // R7
  AST_STRAY_NO_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && (sel == '0) |=> $stable(frame_o)); // R11
endmodule

// File: tb/mask_frame_regs_tb.sv
module mask_frame_regs_tb_top;
  localparam logic [15:0] LO = 16'h0D04;
  localparam logic [15:0] HI = 16'h0D00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, frame;

  int n_tests = 0;
  int n_fail  = 0;
  logic [15:0] m_lo = '0, m_hi = '0;

  always #5 clk = ~clk;

  mask_frame_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .frame_o(frame)
  );

  function automatic logic [15:0] exp_merge(logic [15:0] cur, logic [31:0] w);
    return (cur & ~w[31:16]) | (w[15:0] & w[31:16]);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // drive at negedge; frame must hold until the edge, then follow the model
  task automatic bus_write(logic [15:0] a, logic [31:0] w, string req);
    @(negedge clk);
    addr = a; we = 1'b1; wdata = w;
    #1 check("R10 pre-edge", frame, {m_hi, m_lo});
    if (a == LO) m_lo = exp_merge(m_lo, w);
    else if (a == HI) m_hi = exp_merge(m_hi, w);
    @(negedge clk);
    we = 1'b0;
    check(req, frame, {m_hi, m_lo});
  endtask

  task automatic bus_read(logic [15:0] a, string req);
    @(negedge clk);
    addr = a; we = 1'b0;
    #1;
    if (a == LO)      check(req, rdata, {16'h0, m_lo});
    else if (a == HI) check(req, rdata, {16'h0, m_hi});
    else              check(req, rdata, 32'h0);
  endtask

  initial begin
    #2_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'd1234);
    #1 check("R6 in reset", frame, 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R6 after reset", frame, 32'h0);
    bus_read(LO, "R7 reset read lo");

    // R1 R2 R4: low half, mask upper / data lower
    bus_write(LO, 32'h00FF_A5A5, "R1 R2 R4 low masked write");
    bus_write(HI, 32'hF0F0_FFFF, "R5 high masked write");
    bus_write(LO, 32'h0000_FFFF, "R8 zero mask no change");
    bus_write(HI, 32'hFFFF_1234, "R8 full mask replace");
    bus_write(LO, 32'h8001_0000, "R3 clear edge bits keep rest");
    bus_read(HI, "R7 read high");
    bus_read(LO, "R7 read low");
    bus_write(16'h0D08, 32'hFFFF_FFFF, "R11 stray write ignored");
    bus_read(16'h0D08, "R11 stray read zero");

    // R9: back-to-back high then low
    @(negedge clk);
    addr = HI; we = 1'b1; wdata = 32'hFFFF_CAFE;
    m_hi = exp_merge(m_hi, wdata);
    @(negedge clk);
    addr = LO; wdata = 32'hFFFF_BEEF;
    m_lo = exp_merge(m_lo, wdata);
    @(negedge clk);
    we = 1'b0;
    check("R9 back-to-back", frame, 32'hCAFE_BEEF);

    // idle cycles: frame stable
    repeat (3) @(negedge clk);
    check("R10 idle stable", frame, {m_hi, m_lo});

    for (int i = 0; i < 300; i++) begin
      logic [15:0] a;
      logic [3:0]  pick;
      pick = 4'($urandom_range(0, 9));
      a = (pick < 4'd4) ? LO : (pick < 4'd8) ? HI : 16'($urandom);
      bus_write(a, $urandom, "R2 R3 random write");
      if (i % 10 == 0) bus_read(a, "R7 random read");
    end

    finish_run();
  end
endmodule